// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This block decides when a plug-in card's two-wire serial bus (data and clock) may be joined to a live backplane bus. It is fully synchronous. Its four line inputs are already synchronized digital levels: backplane data and clock, and card data and clock. The analog buffering, current sources and edge sensing sit outside it and take their orders from its outputs.

When enabled, the controller first spends a fixed number of cycles initializing. The pull-up enable turns on as that period begins. It then watches the lines and joins the two sides only at a safe point. All four lines must be HIGH, and then either a STOP appears on the backplane pair or the lines stay HIGH for a full idle interval. Once joined, it stays joined through any bus traffic. Dropping enable isolates the sides at once and turns every output off. Raising enable again restarts the whole sequence.

Top module: `hotswap_join_ctrl`

## Requirements
- R1: While reset is asserted, and after its release with `enable_i` low, `join_o`, `ready_o`, `accel_en_o` and `pullup_en_o` are all 0.
- R2: When `enable_i` is 0, `join_o`, `ready_o`, `accel_en_o` and `pullup_en_o` are 0 in that same cycle. From the next clock edge the controller is back in its off state. This holds even if a join condition occurs in that same cycle.
- R3: After `enable_i` rises, `pullup_en_o` is 1 from the first clock edge. An initialization period of `INIT_CYCLES` cycles follows, during which no join takes place.
- R4: A STOP on the backplane during initialization does not cause a join. STOP detection is armed only once initialization has ended.
- R5: After initialization, the sides join on the `IDLE_CYCLES`-th consecutive clock edge at which all four lines are 1. Any line at 0 restarts that count, so a transfer in progress never causes a join.
- R6: A STOP is `bp_sda_i` going from 0 to 1 while `bp_scl_i` is 1. A STOP in the waiting state, in a cycle where all four lines are 1, joins the sides at the next clock edge.
- R7: While either card line is 0, no join takes place, whether from a STOP or from idle time.
- R8: `ready_o`, `join_o` and `accel_en_o` are 1 exactly while `enable_i` is 1 and the sides are joined.
- R9: Once joined, the sides stay joined while `enable_i` stays 1, whatever the lines do.
- R10: Each time `enable_i` rises again, the full sequence runs once more: pull-up, initialization, then waiting for a safe point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Active-high enable; 0 forces the isolated low-power state |
| bp_sda_i | input | 1 | Backplane data line level |
| bp_scl_i | input | 1 | Backplane clock line level |
| card_sda_i | input | 1 | Card data line level |
| card_scl_i | input | 1 | Card clock line level |
| join_o | output | 1 | Connects the backplane and card sides |
| ready_o | output | 1 | Flag: sides joined and block enabled |
| accel_en_o | output | 1 | Rise-time accelerator enable |
| pullup_en_o | output | 1 | Precharge / pull-up enable |

## Verification
Two events can land in the same cycle: the drop of `enable_i` and a join condition. The bench holds the backplane data line low in the waiting state. It then raises that line (a valid STOP) in the very cycle it lowers `enable_i`, and checks that no output rises at the following edge and that the join stays off. Separately, a STOP on the backplane is issued while the card holds its clock low. This checks that the STOP path and the card-busy condition resolve to no join, and that the idle count starts only when the card releases the line.

// File: rtl/hotswap_join_pkg.sv
package hotswap_join_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_INIT   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_LINKED = 2'd3
  } hsj_state_t;

  // counter width able to hold values 0 .. limit
  function automatic int cnt_width(input int limit);
    int w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // count value at which a window of 'limit' cycles is complete
  function automatic int last_tick(input int limit);
    return (limit < 1) ? 0 : limit - 1;
  endfunction

endpackage

// File: rtl/hsj_window_timer.sv
module hsj_window_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic done_o
);
  import hotswap_join_pkg::*;

  localparam int W    = cnt_width(LIMIT);
  localparam int LAST = last_tick(LIMIT);

  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/hsj_stop_detect.sv
module hsj_stop_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_i,
  output logic stop_o
);
  logic sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev_q <= 1'b1;
    else        sda_prev_q <= sda_i;
  end

  assign stop_o = scl_i & sda_i & ~sda_prev_q;

endmodule

// File: rtl/hotswap_join_ctrl.sv
module hotswap_join_ctrl #(
  parameter int INIT_CYCLES = 16,
  parameter int IDLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic card_sda_i,
  input  logic card_scl_i,
  output logic join_o,
  output logic ready_o,
  output logic accel_en_o,
  output logic pullup_en_o
);
  import hotswap_join_pkg::*;

  hsj_state_t st_q, st_d;

  // named internal events
  logic all_high;
  logic init_done;
  logic idle_done;
  logic stop_hit;
  logic linked;
  logic join_event;

  assign all_high = bp_sda_i & bp_scl_i & card_sda_i & card_scl_i;
  assign linked   = (st_q == ST_LINKED);

  hsj_window_timer #(.LIMIT(INIT_CYCLES)) u_init_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (st_q != ST_INIT),
    .done_o (init_done)
  );

  hsj_window_timer #(.LIMIT(IDLE_CYCLES)) u_idle_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  ((st_q != ST_WAIT) | ~all_high),
    .done_o (idle_done)
  );

  hsj_stop_detect u_stop (
    .clk    (clk),
    .rst_n  (rst_n),
    .sda_i  (bp_sda_i),
    .scl_i  (bp_scl_i),
    .stop_o (stop_hit)
  );

  assign join_event = (st_q == ST_WAIT) & all_high & (stop_hit | idle_done);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:    st_d = ST_INIT;
      ST_INIT:   if (init_done)  st_d = ST_WAIT;
      ST_WAIT:   if (join_event) st_d = ST_LINKED;
      ST_LINKED: st_d = ST_LINKED;
      default:   st_d = ST_OFF;
    endcase
    if (!enable_i) st_d = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign join_o      = enable_i & linked;
  assign ready_o     = enable_i & linked;
  assign accel_en_o  = enable_i & linked;
  assign pullup_en_o = enable_i & (st_q != ST_OFF);

  // ---------------- assertions ----------------
  p_off_after_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (st_q == ST_OFF))
    else $error("R2: state not off after enable low");

  p_wait_after_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && $past(st_q) != ST_WAIT) |-> ($past(st_q) == ST_INIT && $past(init_done)))
    else $error("R3: waiting state entered without full initialization");

  p_join_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (linked && $past(st_q) != ST_LINKED) |-> ($past(st_q) == ST_WAIT && $past(stop_hit || idle_done)))
    else $error("R5: join without stop or idle window");

  p_join_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (linked && $past(st_q) != ST_LINKED) |-> ($past(card_sda_i) && $past(card_scl_i) && $past(bp_scl_i)))
    else $error("R7: join while a line was low");

  p_linked_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (linked && enable_i) |=> linked)
    else $error("R9: link dropped while enabled");

endmodule

// File: tb/hotswap_join_ctrl_test.sv
module hotswap_join_ctrl_test;

  localparam int INIT_N = 16;
  localparam int IDLE_N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_i = 1'b0;
  logic bp_sda_i = 1'b1, bp_scl_i = 1'b1, card_sda_i = 1'b1, card_scl_i = 1'b1;
  logic join_o, ready_o, accel_en_o, pullup_en_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  hotswap_join_ctrl #(.INIT_CYCLES(INIT_N), .IDLE_CYCLES(IDLE_N)) uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
    .bp_sda_i(bp_sda_i), .bp_scl_i(bp_scl_i),
    .card_sda_i(card_sda_i), .card_scl_i(card_scl_i),
    .join_o(join_o), .ready_o(ready_o),
    .accel_en_o(accel_en_o), .pullup_en_o(pullup_en_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected outputs when joined (1) or not (0), pull-up expected separately
  task automatic chk_out(input string tag, input bit j, input bit pu);
    logic [3:0] act, exp;
    act = {join_o, ready_o, accel_en_o, pullup_en_o};
    exp = {j, j, j, pu};
    chk(act == exp, tag, int'(act), int'(exp));
  endtask

  task automatic lines(input bit bsda, input bit bscl, input bit csda, input bit cscl);
    bp_sda_i = bsda; bp_scl_i = bscl; card_sda_i = csda; card_scl_i = cscl;
  endtask

  task automatic t_reset;
    chk_out("R1 during reset", 0, 0);
    step(2);
    rst_n = 1'b1;
    step(3);
    chk_out("R1 after reset, disabled", 0, 0);
  endtask

  task automatic t_idle_join;
    lines(1, 1, 1, 1);
    enable_i = 1'b1;
    step(1);
    chk_out("R3 pull-up at init start", 0, 1);
    step(INIT_N);
    chk_out("R3 no join across init", 0, 1);
    step(IDLE_N - 1);
    chk_out("R5 one edge before idle window", 0, 1);
    step(1);
    chk_out("R5 R8 joined after idle window", 1, 1);
  endtask

  task automatic t_activity_kept;
    for (int i = 0; i < 12; i++) begin
      bp_scl_i = ~bp_scl_i;
      if (i % 3 == 0) card_sda_i = ~card_sda_i;
      step(1);
    end
    chk_out("R9 stays joined through traffic", 1, 1);
    lines(1, 1, 1, 1);
  endtask

  task automatic t_disable;
    enable_i = 1'b0;
    #1;
    chk_out("R2 outputs drop same cycle", 0, 0);
    step(1);
    chk_out("R2 off after edge", 0, 0);
  endtask

  task automatic t_stop_join;
    lines(0, 1, 1, 1);
    enable_i = 1'b1;
    step(1);
    chk_out("R10 re-enable restarts pull-up", 0, 1);
    step(3);
    bp_sda_i = 1'b1;          // STOP inside init
    step(1);
    chk_out("R4 stop during init ignored", 0, 1);
    bp_sda_i = 1'b0;
    step(INIT_N + 4);
    chk_out("R4 no join after init with data low", 0, 1);
    step(IDLE_N + 4);
    chk_out("R5 low data blocks idle join", 0, 1);
    bp_sda_i = 1'b1;          // STOP in waiting state
    step(1);
    chk_out("R6 stop joins at next edge", 1, 1);
  endtask

  task automatic t_transfer;
    bit ok;
    t_disable();
    lines(1, 1, 1, 1);
    enable_i = 1'b1;
    step(1 + INIT_N);
    bp_sda_i = 1'b0;          // START
    step(2);
    ok = 1'b1;
    for (int b = 0; b < 40; b++) begin
      bp_scl_i = 1'b0; step(1);
      bp_sda_i = b[0] ^ b[2]; card_sda_i = ~b[1] | b[0]; step(1);
      bp_scl_i = 1'b1; step(1);
      if (join_o || ready_o) ok = 1'b0;
      step(1);
      if (join_o || ready_o) ok = 1'b0;
    end
    chk(ok, "R5 no join during transfer", int'(ok), 1);
    bp_scl_i = 1'b0; step(1);
    bp_sda_i = 1'b0; card_sda_i = 1'b1; step(1);
    bp_scl_i = 1'b1; step(1);
    chk_out("R6 not joined before stop", 0, 1);
    bp_sda_i = 1'b1;
    step(1);
    chk_out("R6 stop after transfer joins", 1, 1);
  endtask

  task automatic t_card_busy;
    t_disable();
    lines(0, 1, 1, 0);
    enable_i = 1'b1;
    step(1 + INIT_N + 2);
    bp_sda_i = 1'b1;          // backplane STOP while card stretches clock
    step(1);
    chk_out("R7 stop ignored while card line low", 0, 1);
    step(IDLE_N + 4);
    chk_out("R7 idle ignored while card line low", 0, 1);
    card_scl_i = 1'b1;
    step(IDLE_N - 1);
    chk_out("R5 count starts at card release", 0, 1);
    step(1);
    chk_out("R5 joined after card release window", 1, 1);
  endtask

  task automatic t_disable_vs_stop;
    t_disable();
    lines(0, 1, 1, 1);
    enable_i = 1'b1;
    step(1 + INIT_N + 3);
    bp_sda_i = 1'b1;          // STOP in the same cycle as enable drop
    enable_i = 1'b0;
    #1;
    chk_out("R2 disable wins same cycle", 0, 0);
    step(1);
    chk_out("R2 no join after coincident stop", 0, 0);
    step(IDLE_N + 2);
    chk_out("R2 stays off while disabled", 0, 0);
  endtask

  initial begin
    t_reset();
    t_idle_join();
    t_activity_kept();
    t_disable();
    t_stop_join();
    t_transfer();
    t_card_busy();
    t_disable_vs_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule